// File: doc/BRIEF.md
# Coarse and Fine Delay Splitter with Fine-Stage Linearization

This block takes a requested delay, expressed in 10 ps steps, and separates it into two pieces. The first is a whole number of 1 ns sample-clock periods, handed to the counter that replays stored waveform segments. The second is a code for an external programmable fine delay element that covers the sub-clock remainder. That element does not respond linearly. So the remainder (0 to 99 steps) is not sent to it directly. It is used as the address of a correction table, and the table holds the inverse of the element's measured delay curve.

A request falls outside the supported window when it is shorter than 1 us (100,000 steps) or longer than 1 ms (100,000,000 steps). Such a request is pulled to the nearer limit, and a range flag marks the result. The split uses a bit-serial restoring divider by 100, so every conversion takes the same number of cycles. While a conversion is running, the block refuses new requests. The correction table is loaded through an address, data and write-enable port. After reset it holds the identity mapping.

Top module: `delay_splitter`

## Requirements
- R1: For an accepted request, `out_coarse` equals the clamped request divided by 100, with the fraction discarded.
- R2: `out_fine` equals the correction-table entry at the address (clamped request mod 100). The entry is read as it stands just before the clock edge that raises `out_valid`.
- R3: A request below 100,000 is converted as exactly 100,000, and `out_range_err` is 1 with that result.
- R4: A request above 100,000,000 is converted as exactly 100,000,000, and `out_range_err` is 1. A request from 100,000 to 100,000,000 inclusive gives `out_range_err` = 0.
- R5: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `out_valid` is then 1 for exactly one cycle, starting 28 rising edges after the accepting edge.
- R6: `req_ready` is 0 from the cycle after an accepting edge up to the cycle in which `out_valid` is 1. A `req_valid` seen while `req_ready` is 0 is dropped and produces no result.
- R7: A write with `tbl_wr_en` = 1 at address 0 to 99 replaces that entry with `tbl_wr_data`. A write at address 100 to 127 changes no entry.
- R8: After reset, entry i of the table holds i, `req_ready` is 1, and `out_valid`, `out_coarse`, `out_fine` and `out_range_err` are 0.
- R9: `out_coarse`, `out_fine` and `out_range_err` keep their values in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Delay request present |
| req_delay | input | 32 | Requested delay in 10 ps steps |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| tbl_wr_en | input | 1 | Correction-table write strobe |
| tbl_wr_addr | input | 7 | Correction-table entry index |
| tbl_wr_data | input | 10 | Fine code to store |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_coarse | output | 20 | Whole sample-clock periods |
| out_fine | output | 10 | Linearized fine delay code |
| out_range_err | output | 1 | Request was clamped to a limit |

## Verification
Every result appears 28 rising edges after the edge that accepts its request, and `req_ready` falls in the very next cycle. The bench model counts these edges down from the acceptance edge, one per clock. It compares `out_valid`, `req_ready` and all three result fields at the falling edge of every cycle, so a result that arrives one cycle early or late fails. The fine code is looked up in the model's own copy of the table when the countdown reaches zero, before that edge's write is applied. This covers the case of a table write made during a conversion. Requests held on the input while the block is busy must leave no trace in the compared stream.

// File: rtl/dsplit_pkg.sv
package dsplit_pkg;

    localparam int REQ_W         = 32;
    localparam int UNITS_PER_CLK = 100;
    localparam int MIN_REQ       = 100_000;
    localparam int MAX_REQ       = 100_000_000;
    localparam int FINE_W        = 10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } dsplit_state_e;

endpackage

// File: rtl/dsplit_range_clamp.sv
module dsplit_range_clamp #(
    parameter int REQ_W   = 32,
    parameter int MIN_REQ = 100_000,
    parameter int MAX_REQ = 100_000_000,
    localparam int DIV_W  = $clog2(MAX_REQ + 1)
) (
    input  logic [REQ_W-1:0] req,
    output logic [DIV_W-1:0] value,
    output logic             out_of_range
);

    logic too_low, too_high;

    assign too_low      = req < REQ_W'(MIN_REQ);
    assign too_high     = req > REQ_W'(MAX_REQ);
    assign out_of_range = too_low | too_high;

    always_comb begin
        if (too_low)       value = DIV_W'(MIN_REQ);
        else if (too_high) value = DIV_W'(MAX_REQ);
        else               value = req[DIV_W-1:0];
    end

endmodule

// File: rtl/dsplit_divider.sv
module dsplit_divider #(
    parameter int DIV_W   = 27,
    parameter int QUOT_W  = 20,
    parameter int DIVISOR = 100,
    localparam int REM_W  = $clog2(DIVISOR),
    localparam int CNT_W  = $clog2(DIV_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIV_W-1:0]  dividend,
    output logic              done,
    output logic [QUOT_W-1:0] quot,
    output logic [REM_W-1:0]  rem
);

    logic [DIV_W-1:0] q_q;
    logic [REM_W-1:0] r_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    logic [REM_W:0]   r_shift;
    logic             fits;
    logic [REM_W-1:0] r_next;
    logic [DIV_W-1:0] q_next;

    always_comb begin
        r_shift = {r_q, q_q[DIV_W-1]};
        fits    = r_shift >= (REM_W+1)'(DIVISOR);
        r_next  = fits ? REM_W'(r_shift - (REM_W+1)'(DIVISOR)) : r_shift[REM_W-1:0];
        q_next  = {q_q[DIV_W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q   <= '0;
            r_q   <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q_q   <= dividend;
                r_q   <= '0;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                q_q <= q_next;
                r_q <= r_next;
                if (cnt_q == CNT_W'(DIV_W - 1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign quot = q_q[QUOT_W-1:0];
    assign rem  = r_q;

endmodule

// File: rtl/dsplit_corr_table.sv
module dsplit_corr_table #(
    parameter int DEPTH   = 100,
    parameter int CODE_W  = 10,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CODE_W-1:0] rd_data
);

    logic [CODE_W-1:0] entry_q [DEPTH];
    logic              wr_hit;
    logic              rd_hit;

    assign wr_hit = wr_en && ({1'b0, wr_addr} < (ADDR_W+1)'(DEPTH));
    assign rd_hit = {1'b0, rd_addr} < (ADDR_W+1)'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) entry_q[i] <= CODE_W'(i);
        end else if (wr_hit) begin
            entry_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = rd_hit ? entry_q[rd_addr] : '0;

endmodule

// File: rtl/delay_splitter.sv
module delay_splitter #(
    parameter int REQ_W         = dsplit_pkg::REQ_W,
    parameter int UNITS_PER_CLK = dsplit_pkg::UNITS_PER_CLK,
    parameter int MIN_REQ       = dsplit_pkg::MIN_REQ,
    parameter int MAX_REQ       = dsplit_pkg::MAX_REQ,
    parameter int FINE_W        = dsplit_pkg::FINE_W,
    localparam int DIV_W        = $clog2(MAX_REQ + 1),
    localparam int COARSE_W     = $clog2(MAX_REQ / UNITS_PER_CLK + 1),
    localparam int REM_W        = $clog2(UNITS_PER_CLK)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [REQ_W-1:0]    req_delay,
    output logic                req_ready,
    input  logic                tbl_wr_en,
    input  logic [REM_W-1:0]    tbl_wr_addr,
    input  logic [FINE_W-1:0]   tbl_wr_data,
    output logic                out_valid,
    output logic [COARSE_W-1:0] out_coarse,
    output logic [FINE_W-1:0]   out_fine,
    output logic                out_range_err
);
    import dsplit_pkg::*;

    dsplit_state_e       state_q;
    logic [DIV_W-1:0]    clamped;
    logic                clamp_err;
    logic                err_q;
    logic                start;
    logic                div_done;
    logic [COARSE_W-1:0] div_quot;
    logic [REM_W-1:0]    div_rem;
    logic [FINE_W-1:0]   tbl_code;

    dsplit_range_clamp #(
        .REQ_W(REQ_W), .MIN_REQ(MIN_REQ), .MAX_REQ(MAX_REQ)
    ) u_clamp (
        .req(req_delay), .value(clamped), .out_of_range(clamp_err)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign start     = req_ready && req_valid;

    dsplit_divider #(
        .DIV_W(DIV_W), .QUOT_W(COARSE_W), .DIVISOR(UNITS_PER_CLK)
    ) u_div (
        .clk(clk), .rst(rst), .start(start), .dividend(clamped),
        .done(div_done), .quot(div_quot), .rem(div_rem)
    );

    dsplit_corr_table #(
        .DEPTH(UNITS_PER_CLK), .CODE_W(FINE_W)
    ) u_tbl (
        .clk(clk), .rst(rst), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
        .wr_data(tbl_wr_data), .rd_addr(div_rem), .rd_data(tbl_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            err_q         <= 1'b0;
            out_valid     <= 1'b0;
            out_coarse    <= '0;
            out_fine      <= '0;
            out_range_err <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        err_q   <= clamp_err;
                        state_q <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (div_done) begin
                        out_coarse    <= div_quot;
                        out_fine      <= tbl_code;
                        out_range_err <= err_q;
                        out_valid     <= 1'b1;
                        state_q       <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dsplit_checker.sv
module dsplit_checker #(
    parameter int COARSE_W = 20,
    parameter int FINE_W   = 10,
    parameter int C_MIN    = 1000,
    parameter int C_MAX    = 1_000_000
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                out_valid,
    input logic [COARSE_W-1:0] out_coarse,
    input logic [FINE_W-1:0]   out_fine,
    input logic                out_range_err
);

    // R5
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    result_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$past(req_ready));

    // R3
    coarse_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_coarse >= COARSE_W'(C_MIN) && out_coarse <= COARSE_W'(C_MAX)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_coarse) && $stable(out_fine) && $stable(out_range_err)));

endmodule

bind delay_splitter dsplit_checker #(
    .COARSE_W(COARSE_W), .FINE_W(FINE_W),
    .C_MIN(MIN_REQ / UNITS_PER_CLK), .C_MAX(MAX_REQ / UNITS_PER_CLK)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .out_valid(out_valid), .out_coarse(out_coarse), .out_fine(out_fine),
    .out_range_err(out_range_err)
);

// File: tb/delay_splitter_test.sv
module delay_splitter_test;

    localparam int LAT = 28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_delay = '0;
    logic        req_ready;
    logic        tbl_wr_en = 1'b0;
    logic [6:0]  tbl_wr_addr = '0;
    logic [9:0]  tbl_wr_data = '0;
    logic        out_valid;
    logic [19:0] out_coarse;
    logic [9:0]  out_fine;
    logic        out_range_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural reference state
    int  tbl[100];
    bit  m_busy;
    int  m_cnt, m_coarse, m_rem;
    bit  m_err;
    bit  e_valid, e_ready, e_err;
    int  e_coarse, e_fine;

    always #4 clk = ~clk;

    delay_splitter uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_delay(req_delay),
        .req_ready(req_ready), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_data(tbl_wr_data), .out_valid(out_valid), .out_coarse(out_coarse),
        .out_fine(out_fine), .out_range_err(out_range_err)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model();
        if (rst) begin
            for (int i = 0; i < 100; i++) tbl[i] = i;
            m_busy = 0; m_cnt = 0; e_valid = 0; e_ready = 1;
            e_coarse = 0; e_fine = 0; e_err = 0;
        end else begin
            e_valid = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    e_valid = 1; e_coarse = m_coarse; e_fine = tbl[m_rem];
                    e_err = m_err; m_busy = 0;
                end
            end else if (req_valid) begin
                longint v;
                v = longint'(req_delay);
                m_err = 0;
                if (v < 100000) begin v = 100000; m_err = 1; end
                if (v > 100000000) begin v = 100000000; m_err = 1; end
                m_coarse = int'(v / 100); m_rem = int'(v % 100);
                m_busy = 1; m_cnt = LAT;
            end
            if (tbl_wr_en && tbl_wr_addr < 100) tbl[tbl_wr_addr] = tbl_wr_data;
            e_ready = !m_busy;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model();
        @(negedge clk);
        if (!rst) begin
            check("R5 out_valid", out_valid, e_valid);
            check("R6 req_ready", req_ready, e_ready);
            check("R1 R9 out_coarse", out_coarse, e_coarse);
            check("R2 R7 out_fine", out_fine, e_fine);
            check("R3 R4 out_range_err", out_range_err, e_err);
        end
    endtask

    task automatic wait_idle();
        while (m_busy) step();
        step();
    endtask

    task automatic send(int unsigned v);
        req_valid = 1; req_delay = v;
        step();
        req_valid = 0;
        wait_idle();
    endtask

    task automatic wr(int a, int d);
        tbl_wr_en = 1; tbl_wr_addr = 7'(a); tbl_wr_data = 10'(d);
        step();
        tbl_wr_en = 0;
    endtask

    initial begin
        repeat (3) step();
        rst = 0;
        // R8 reset state
        check("R8 ready after reset", req_ready, 1);
        check("R8 valid after reset", out_valid, 0);
        check("R8 coarse after reset", out_coarse, 0);
        check("R8 fine after reset", out_fine, 0);
        step();

        // R8 identity table, R1 R2 in-range
        send(100000);
        send(543210);
        send(99999999);
        send(100099);
        // R3 low clamp
        send(99999);
        send(0);
        // R4 high clamp
        send(100000000);
        send(100000001);
        send(32'hFFFF_FFFF);

        // R6 requests held while busy are dropped
        req_valid = 1; req_delay = 250017;
        step();
        req_delay = 777777;
        repeat (10) step();
        req_valid = 0;
        wait_idle();

        // R7 nonlinear table load, out-of-range addresses ignored
        for (int i = 0; i < 100; i++) wr(i, (i * i) / 12 + i / 3);
        wr(100, 1023);
        wr(127, 1023);
        send(100027);
        send(300000);
        send(456799);

        // R2 write during a conversion is seen by its lookup
        req_valid = 1; req_delay = 200042;
        step();
        req_valid = 0;
        repeat (5) step();
        wr(42, 777);
        wait_idle();

        // R5 back-to-back with request held high
        for (int k = 0; k < 25; k++) begin
            req_valid = 1; req_delay = 100000 + k * 3999977;
            step();
            while (m_busy) step();
        end
        req_valid = 0;
        wait_idle();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule